// File: doc/BRIEF.md
# GPIO Bank with Pull Control and Alternate-Function Mux

This block controls a bank of general-purpose pads through a small word-addressed register port. Software sets each pin's direction with an active-low drive-enable register. It writes the value to drive into an output register and chooses pull resistors through two separate registers. One register enables the pull and the other sets its direction. Pad levels pass through a two-stage synchroniser into a read-only input register.

Each pin can also be given to one of several peripheral functions. Every function of every pin has its own enable bit in a set of mux registers. A command register selects function f for one pin in one write: it sets that function's bit and clears the pin's other function bits. While a function is active, the pad's output and drive enable come from that peripheral. The peripheral also receives the pad level.

The output-value and pull-direction fields sit at bit `n + OUT_SHIFT` for pin n. The drive-enable, pull-enable and input fields stay at bit n.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the drive-enable register reads all pin bits set (0x3FFF for the default 14 pins). The output, pull-enable, pull-direction and all mux registers read 0. `pad_oe` and `pad_pull_en` are 0. Register addresses are: 0 drive-enable, 1 output, 2 input, 3 pull-enable, 4 pull-direction, 5 function command, and 6 onward the mux registers.
- R2: For a pin with no active function, drive-enable bit n = 0 makes `pad_oe[n]` = 1 and bit n = 1 makes it 0. `pad_out[n]` equals output-register bit n+OUT_SHIFT (16 by default).
- R3: The output register keeps its value while a pin is an input. Clearing drive-enable then drives the stored value at once.
- R4: `pad_pull_en[n]` equals pull-enable bit n. `pad_pull_up[n]` is 1 only when pull-enable bit n and pull-direction bit n+OUT_SHIFT are both 1. A direction bit with its enable clear gives no pull-up.
- R5: Write-data bits outside a register's pin field are dropped and read back as 0. Examples: output bits below OUT_SHIFT, or drive-enable bits at or above NPIN.
- R6: The input register (address 2) returns the pad level of pin n at bit n. A pad change is visible after the second rising clock edge and not after the first.
- R7: A write to address 5 with pin in bits [7:0] and function f in bits [11:8] behaves as follows. For 1 <= f <= NFUNC it sets that pin's function-f bit and clears its other function bits. For f = 0 it clears all of that pin's function bits. Other pins are unchanged.
- R8: A function-command write with f > NFUNC or pin >= NPIN changes no mux bit.
- R9: With the default by-function layout, the enable bit for function f of pin p sits in register 6+(f-1) at bit p. Direct writes to the mux registers store the pin field, and the stored bits read back.
- R10: While a pin has any function bit set, `pad_out` and `pad_oe` come from `alt_out` and `alt_oe` at index (f-1)*NPIN+p of the lowest-numbered function set. The GPIO registers are then ignored.
- R11: `alt_in` at index (f-1)*NPIN+p carries the pad level of pin p only while function f is the one in effect for that pin, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| pad_in | input | NPIN | Pad levels |
| pad_out | output | NPIN | Value to drive on each pad |
| pad_oe | output | NPIN | Active-high pad drive enable |
| pad_pull_en | output | NPIN | Pull resistor enable |
| pad_pull_up | output | NPIN | Pull-up select (pull-down when enabled and 0) |
| alt_out | input | NFUNC*NPIN | Peripheral output per function and pin |
| alt_oe | input | NFUNC*NPIN | Peripheral drive enable per function and pin |
| alt_in | output | NFUNC*NPIN | Pad level routed to the selected peripheral |

## Verification
Output steering is tried three ways, each confirming a different source is in control:
- Pins driven from the GPIO registers, with their output-value bits preset.
- The same pins switched to input and back, which shows the stored value survives the change.
- Pins handed to a peripheral whose enable and value differ from the registers.

A pin with two function bits set by direct mux writes, and peripherals driving opposite values, separates lowest-function priority from any other choice.

Input sampling uses a pattern that differs from the previous one in many bits, read once after one edge and once after two. This distinguishes a correct two-stage synchroniser from a shorter or longer one.

Function commands with valid, zero, out-of-range and bad-pin arguments, read back through the mux registers, show what each command touches.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int A_OEN  = 0;
    localparam int A_OUT  = 1;
    localparam int A_IN   = 2;
    localparam int A_PEN  = 3;
    localparam int A_PDIR = 4;
    localparam int A_FSEL = 5;
    localparam int A_MUX  = 6;

    localparam int FSEL_PIN_LSB = 0;
    localparam int FSEL_PIN_W   = 8;
    localparam int FSEL_FN_LSB  = 8;
    localparam int FSEL_FN_W    = 4;

    // f is zero-based here (function 1 is f = 0)
    function automatic int mux_reg_idx(int p, int f, int nfunc, bit by_pin, int dw);
        if (by_pin) return (p * nfunc + f) / dw;
        return f;
    endfunction

    function automatic int mux_bit_idx(int p, int f, int nfunc, bit by_pin, int dw);
        if (by_pin) return (p * nfunc + f) % dw;
        return p;
    endfunction

    function automatic int n_mux_regs(int npin, int nfunc, bit by_pin, int dw);
        if (by_pin) return (npin * nfunc + dw - 1) / dw;
        return nfunc;
    endfunction

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_bank_pkg::*;
#(
    parameter int NPIN       = 14,
    parameter int NFUNC      = 4,
    parameter int OUT_SHIFT  = 16,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter bit MUX_BY_PIN = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [NPIN-1:0]        oen,
    output logic [NPIN-1:0]        outv,
    output logic [NPIN-1:0]        pen,
    output logic [NPIN-1:0]        pdir,
    output logic [NPIN*NFUNC-1:0]  fen
);

    typedef struct packed {
        logic [NPIN-1:0]       oen;
        logic [NPIN-1:0]       outv;
        logic [NPIN-1:0]       pen;
        logic [NPIN-1:0]       pdir;
        logic [NPIN*NFUNC-1:0] fen;
    } st_t;

    st_t st_d, st_q;

    logic [FSEL_PIN_W-1:0] cmd_pin;
    logic [FSEL_FN_W-1:0]  cmd_fn;
    logic                  cmd_ok;
    int                    a;

    always_comb begin
        cmd_pin = wdata[FSEL_PIN_LSB +: FSEL_PIN_W];
        cmd_fn  = wdata[FSEL_FN_LSB +: FSEL_FN_W];
        cmd_ok  = (int'(cmd_pin) < NPIN) && (int'(cmd_fn) <= NFUNC);
        a       = int'(addr);
        st_d    = st_q;
        if (we) begin
            if (a == A_OEN)  st_d.oen  = wdata[NPIN-1:0];
            if (a == A_OUT)  st_d.outv = wdata[OUT_SHIFT +: NPIN];
            if (a == A_PEN)  st_d.pen  = wdata[NPIN-1:0];
            if (a == A_PDIR) st_d.pdir = wdata[OUT_SHIFT +: NPIN];
            if (a == A_FSEL && cmd_ok) begin
                for (int p = 0; p < NPIN; p++) begin
                    if (int'(cmd_pin) == p) begin
                        for (int f = 0; f < NFUNC; f++) begin
                            st_d.fen[p*NFUNC+f] = (int'(cmd_fn) == f + 1);
                        end
                    end
                end
            end
            for (int p = 0; p < NPIN; p++) begin
                for (int f = 0; f < NFUNC; f++) begin
                    if (a == A_MUX + mux_reg_idx(p, f, NFUNC, MUX_BY_PIN, DATA_W)) begin
                        st_d.fen[p*NFUNC+f] =
                            wdata[mux_bit_idx(p, f, NFUNC, MUX_BY_PIN, DATA_W)];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.oen  <= '1;
            st_q.outv <= '0;
            st_q.pen  <= '0;
            st_q.pdir <= '0;
            st_q.fen  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oen  = st_q.oen;
    assign outv = st_q.outv;
    assign pen  = st_q.pen;
    assign pdir = st_q.pdir;
    assign fen  = st_q.fen;

endmodule

// File: rtl/gpio_insync.sv
module gpio_insync #(
    parameter int NPIN = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] din,
    output logic [NPIN-1:0] dout
);

    typedef struct packed {
        logic [NPIN-1:0] s1;
        logic [NPIN-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = din;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign dout = sy_q.s2;

endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
    parameter int NPIN  = 14,
    parameter int NFUNC = 4
) (
    input  logic [NPIN*NFUNC-1:0] fen,
    input  logic [NPIN-1:0]       oen,
    input  logic [NPIN-1:0]       outv,
    input  logic [NPIN-1:0]       pad_in,
    input  logic [NFUNC*NPIN-1:0] alt_out,
    input  logic [NFUNC*NPIN-1:0] alt_oe,
    output logic [NPIN-1:0]       pad_out,
    output logic [NPIN-1:0]       pad_oe,
    output logic [NFUNC*NPIN-1:0] alt_in
);

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [NFUNC-1:0] req;
        logic [NFUNC-1:0] grant;
        logic             act;
        logic             a_out;
        logic             a_oe;

        assign req = fen[p*NFUNC +: NFUNC];
        assign act = |req;

        // lowest-numbered function wins
        always_comb begin
            grant = '0;
            a_out = 1'b0;
            a_oe  = 1'b0;
            for (int f = NFUNC - 1; f >= 0; f--) begin
                if (req[f]) begin
                    grant = '0;
                    grant[f] = 1'b1;
                    a_out = alt_out[f*NPIN+p];
                    a_oe  = alt_oe[f*NPIN+p];
                end
            end
        end

        assign pad_out[p] = act ? a_out : outv[p];
        assign pad_oe[p]  = act ? a_oe  : ~oen[p];

        for (genvar f = 0; f < NFUNC; f++) begin : g_fn
            assign alt_in[f*NPIN+p] = pad_in[p] & grant[f];
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPIN       = 14,
    parameter int NFUNC      = 4,
    parameter int OUT_SHIFT  = 16,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter bit MUX_BY_PIN = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    input  logic [NPIN-1:0]        pad_in,
    output logic [NPIN-1:0]        pad_out,
    output logic [NPIN-1:0]        pad_oe,
    output logic [NPIN-1:0]        pad_pull_en,
    output logic [NPIN-1:0]        pad_pull_up,
    input  logic [NFUNC*NPIN-1:0]  alt_out,
    input  logic [NFUNC*NPIN-1:0]  alt_oe,
    output logic [NFUNC*NPIN-1:0]  alt_in
);

    localparam int NMUX = n_mux_regs(NPIN, NFUNC, MUX_BY_PIN, DATA_W);

    logic [NPIN-1:0]       oen;
    logic [NPIN-1:0]       out_bits;
    logic [NPIN-1:0]       pen;
    logic [NPIN-1:0]       pdir;
    logic [NPIN*NFUNC-1:0] fen;
    logic [NPIN-1:0]       in_sync;

    gpio_regfile #(
        .NPIN(NPIN), .NFUNC(NFUNC), .OUT_SHIFT(OUT_SHIFT),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MUX_BY_PIN(MUX_BY_PIN)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .oen(oen), .outv(out_bits), .pen(pen), .pdir(pdir), .fen(fen)
    );

    gpio_insync #(.NPIN(NPIN)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(in_sync)
    );

    gpio_pinmux #(.NPIN(NPIN), .NFUNC(NFUNC)) u_mux (
        .fen(fen), .oen(oen), .outv(out_bits), .pad_in(pad_in),
        .alt_out(alt_out), .alt_oe(alt_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .alt_in(alt_in)
    );

    assign pad_pull_en = pen;
    assign pad_pull_up = pen & pdir;

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) == A_OEN)  reg_rdata[NPIN-1:0] = oen;
        if (int'(reg_addr) == A_OUT)  reg_rdata[OUT_SHIFT +: NPIN] = out_bits;
        if (int'(reg_addr) == A_IN)   reg_rdata[NPIN-1:0] = in_sync;
        if (int'(reg_addr) == A_PEN)  reg_rdata[NPIN-1:0] = pen;
        if (int'(reg_addr) == A_PDIR) reg_rdata[OUT_SHIFT +: NPIN] = pdir;
        for (int r = 0; r < NMUX; r++) begin
            if (int'(reg_addr) == A_MUX + r) begin
                for (int p = 0; p < NPIN; p++) begin
                    for (int f = 0; f < NFUNC; f++) begin
                        if (mux_reg_idx(p, f, NFUNC, MUX_BY_PIN, DATA_W) == r) begin
                            reg_rdata[mux_bit_idx(p, f, NFUNC, MUX_BY_PIN, DATA_W)] =
                                fen[p*NFUNC+f];
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPIN   = 14,
    parameter int NFUNC  = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_we,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic [DATA_W-1:0]     reg_wdata,
    input logic [NPIN-1:0]       pad_in,
    input logic [NPIN-1:0]       pad_pull_en,
    input logic [NPIN-1:0]       pad_pull_up,
    input logic [NPIN-1:0]       in_sync,
    input logic [NPIN-1:0]       out_bits,
    input logic [NPIN*NFUNC-1:0] fen
);

    logic [1:0]            since_rst;
    logic                  cmd_hit;
    logic                  cmd_ok;
    logic                  ok_q;
    logic [FSEL_PIN_W-1:0] pin_q;
    logic [FSEL_FN_W-1:0]  fn_q;
    logic [NFUNC-1:0]      slice;

    assign cmd_hit = reg_we && (int'(reg_addr) == A_FSEL);
    assign cmd_ok  = (int'(reg_wdata[FSEL_PIN_LSB +: FSEL_PIN_W]) < NPIN) &&
                     (int'(reg_wdata[FSEL_FN_LSB +: FSEL_FN_W]) <= NFUNC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
            ok_q      <= 1'b0;
            pin_q     <= '0;
            fn_q      <= '0;
        end else begin
            if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
            ok_q  <= cmd_hit && cmd_ok;
            pin_q <= reg_wdata[FSEL_PIN_LSB +: FSEL_PIN_W];
            fn_q  <= reg_wdata[FSEL_FN_LSB +: FSEL_FN_W];
        end
    end

    always_comb begin
        slice = '0;
        for (int p = 0; p < NPIN; p++) begin
            if (int'(pin_q) == p) slice = fen[p*NFUNC +: NFUNC];
        end
    end

    // R4: no pull-up without its enable
    a_r4_pull_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_up & ~pad_pull_en) == '0);

    // R3: output value only moves on a write to its register
    a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && int'(reg_addr) == A_OUT) |=> $stable(out_bits));

    // R6: readable input lags the pad by two edges
    a_r6_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (in_sync == $past(pad_in, 2)));

    // R7: after a valid command the pin holds exactly the requested function
    a_r7_onehot_select: assert property (@(posedge clk) disable iff (!rst_n)
        ok_q |-> ($onehot0(slice) &&
                  (slice == ((fn_q == '0) ? '0 : (NFUNC'(1) << (int'(fn_q) - 1))))));

    // R8: invalid command leaves every mux bit alone
    a_r8_bad_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && !cmd_ok) |=> $stable(fen));

endmodule

bind gpio_bank gpio_bank_chk #(
    .NPIN(NPIN), .NFUNC(NFUNC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pad_in(pad_in), .pad_pull_en(pad_pull_en),
    .pad_pull_up(pad_pull_up), .in_sync(in_sync), .out_bits(out_bits), .fen(fen)
);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;

    localparam int NPIN  = 14;
    localparam int NFUNC = 4;
    localparam int NA    = NFUNC * NPIN;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_we = 1'b0;
    logic [3:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NPIN-1:0] pad_in = '0;
    logic [NPIN-1:0] pad_out, pad_oe, pad_pull_en, pad_pull_up;
    logic [NA-1:0]   alt_out = '0;
    logic [NA-1:0]   alt_oe = '0;
    logic [NA-1:0]   alt_in;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    gpio_bank u_gpio_bank (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
        .pad_pull_up(pad_pull_up), .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        reg_addr = 4'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic fsel(int pin, int fn);
        wr(5, (32'(fn) << 8) | 32'(pin));
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(0, d); chk("R1 oen reset", d, 32'h3FFF);
        rd(1, d); chk("R1 out reset", d, 0);
        rd(3, d); chk("R1 pen reset", d, 0);
        rd(4, d); chk("R1 pdir reset", d, 0);
        for (int r = 6; r < 10; r++) begin
            rd(r, d); chk("R1 mux reset", d, 0);
        end
        chk("R1 pad_oe reset", 32'(pad_oe), 0);
        chk("R1 pull_en reset", 32'(pad_pull_en), 0);
    endtask

    task automatic t_drive;
        logic [31:0] d;
        wr(1, 32'h0005_0000);
        chk("R3 value held while input", 32'(pad_oe), 0);
        wr(0, 32'h3FF8);
        chk("R2 oe low-active", 32'(pad_oe), 32'h7);
        chk("R2 out from shifted field", 32'(pad_out), 32'h5);
        wr(0, 32'h3FFF);
        chk("R2 all inputs", 32'(pad_oe), 0);
        rd(1, d); chk("R3 out kept", d, 32'h0005_0000);
        wr(0, 32'h3FFE);
        chk("R3 redrive oe", 32'(pad_oe), 32'h1);
        chk("R3 redrive value", 32'(pad_out[0]), 1);
    endtask

    task automatic t_field;
        logic [31:0] d;
        wr(1, 32'h0000_FFFF);
        rd(1, d); chk("R5 low out bits dropped", d, 0);
        chk("R5 pad_out zero", 32'(pad_out), 0);
        wr(0, 32'hFFFF_FFFF);
        rd(0, d); chk("R5 oen upper dropped", d, 32'h3FFF);
        wr(4, 32'hFFFF_FFFF);
        rd(4, d); chk("R5 pdir field", d, 32'h3FFF_0000);
        wr(4, 0);
    endtask

    task automatic t_pull;
        wr(3, 32'h3);
        wr(4, 32'h0005_0000);
        chk("R4 pull enable", 32'(pad_pull_en), 32'h3);
        chk("R4 pull up gated", 32'(pad_pull_up), 32'h1);
        wr(3, 0);
        chk("R4 no pull", 32'(pad_pull_up), 0);
    endtask

    task automatic t_input;
        logic [31:0] d;
        @(negedge clk);
        pad_in = 14'h02A5;
        @(negedge clk);
        rd(2, d); chk("R6 one edge not yet", d, 0);
        @(negedge clk);
        rd(2, d); chk("R6 two edges", d, 32'h02A5);
        pad_in = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_fsel;
        logic [31:0] d;
        fsel(5, 1);
        fsel(3, 2);
        rd(7, d); chk("R7 pin3 fn2", d, 32'h8);
        rd(6, d); chk("R7 pin5 untouched", d, 32'h20);
        fsel(3, 4);
        rd(7, d); chk("R7 fn2 cleared", d, 0);
        rd(9, d); chk("R7 fn4 set", d, 32'h8);
        fsel(3, 0);
        rd(9, d); chk("R7 fn0 clears", d, 0);
        rd(6, d); chk("R7 other pin kept", d, 32'h20);
    endtask

    task automatic t_fsel_bad;
        logic [31:0] d;
        fsel(5, 5);
        rd(6, d); chk("R8 fn too large", d, 32'h20);
        fsel(14, 1);
        rd(6, d); chk("R8 pin out of range", d, 32'h20);
        fsel(5, 0);
    endtask

    task automatic t_layout;
        logic [31:0] d;
        wr(8, 32'hFFFF_FFFF);
        rd(8, d); chk("R9 direct mux write", d, 32'h3FFF);
        wr(8, 32'h0000_0400);
        rd(8, d); chk("R9 fn3 pin10 bit", d, 32'h400);
        wr(8, 0);
    endtask

    task automatic t_steer;
        wr(0, 32'h3FFD);
        wr(1, 0);
        fsel(1, 2);
        alt_out = '0; alt_oe = '0;
        alt_out[1*NPIN+1] = 1'b1;
        alt_oe[1*NPIN+1]  = 1'b1;
        #1;
        chk("R10 alt value", 32'(pad_out[1]), 1);
        chk("R10 alt oe", 32'(pad_oe[1]), 1);
        alt_oe[1*NPIN+1] = 1'b0;
        #1;
        chk("R10 registers ignored", 32'(pad_oe[1]), 0);
        alt_oe[0*NPIN+1] = 1'b1;
        wr(6, 32'h2);
        chk("R10 lowest fn priority", 32'(pad_out[1]), 0);
        chk("R10 lowest fn oe", 32'(pad_oe[1]), 1);
        wr(6, 0);
        alt_oe = '0;
        #1;
        chk("R10 back to fn2", 32'(pad_out[1]), 1);
    endtask

    task automatic t_altin;
        @(negedge clk);
        pad_in[1] = 1'b1;
        #1;
        chk("R11 selected fn sees pad", 32'(alt_in[1*NPIN+1]), 1);
        chk("R11 unselected fn zero", 32'(alt_in[0*NPIN+1]), 0);
        fsel(1, 0);
        chk("R11 deselected zero", 32'(alt_in[1*NPIN+1]), 0);
        chk("R10 gpio again", 32'(pad_oe[1]), 1);
        pad_in = '0;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_drive;
        t_field;
        t_pull;
        t_input;
        t_fsel;
        t_fsel_bad;
        t_layout;
        t_steer;
        t_altin;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule